// File: doc/BRIEF.md
# Register-Stack Execution Core

This block is a small, non-pipelined processor whose only working storage is a last-in-first-out stack of 64-bit words held in registers. Every clock it fetches one fixed-length 24-bit instruction from an external instruction memory and retires it in that same cycle. Load-type instructions bring a word from data memory onto the top of the stack. Store-type instructions send the top word back to memory. Arithmetic instructions name no operands: they take the two top entries and replace them with a single result.

The core is intended for short straight-line evaluation programs, such as computing A = A + A*D with a sequence of pushes, a multiply, an add and a store. The external memories are not part of the block. Both have combinational read ports, and data memory is written on the clock edge when the write strobe is high. Stack misuse raises a sticky error flag and the offending instruction is skipped. A halt instruction freezes the core until the next reset.

Top module: `stk_core`

## Requirements
- R1: While `rst_n` is low the program counter is 0, `halted_o` and `err_o` are 0, `dmem_wen_o` is 0, and the stack is empty.
- R2: An instruction is 24 bits, with the opcode in bits [23:18] and a direct data address in bits [17:0]. Opcode 0x00 reads Mem[address] and places the word on top of the stack.
- R3: Opcode 0x01 drives `dmem_wen_o`, with the address field and the top entry as write data, in the cycle it executes, and then removes that entry. Opcodes 0x02 and 0x03 ignore the address field and never write memory.
- R4: Opcode 0x02 replaces the two top entries with their sum modulo 2^64.
- R5: Opcode 0x03 replaces the two top entries with the low 64 bits of their product.
- R6: Entries below the top keep last-in-first-out order. A push moves them down one place, and a pop or arithmetic operation moves them up.
- R7: The stack holds 8 entries. A push onto a full stack sets the error flag and leaves the stack unchanged.
- R8: A pop on an empty stack, or arithmetic with fewer than two entries, sets the error flag, leaves the stack unchanged and writes no memory.
- R9: The error flag stays set until reset, and execution continues with the next instruction.
- R10: Opcode 0x3F raises `halted_o`. From then on the program counter holds, and no memory write occurs until reset.
- R11: Any other opcode does nothing except advance the program counter.
- R12: While the core is not halted, the program counter increases by exactly one every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_addr_o | output | 8 | Instruction fetch address (word index) |
| ins_data_i | input | 24 | Fetched instruction word |
| dmem_raddr_o | output | 18 | Data memory read address |
| dmem_rdata_i | input | 64 | Data memory read data (combinational) |
| dmem_wen_o | output | 1 | Data memory write strobe |
| dmem_waddr_o | output | 18 | Data memory write address |
| dmem_wdata_o | output | 64 | Data memory write data |
| halted_o | output | 1 | Core has executed the halt instruction |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench targets both ends of the stack. A ninth push must be rejected, so that the later pops return the eighth value. A pop on an empty stack must not write memory. A design that checks the bounds off by one would corrupt a sentinel location or pop the wrong value. Operand order and truncation are probed with a sum that wraps past 2^64 and a product whose upper half must be dropped. An arithmetic instruction carries a live-looking address field to catch a spurious write. Further tests check that halt freezes fetch with a store waiting behind it, and that an unknown opcode sets no error and leaves the stack untouched.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int OPC_W  = 6;
    localparam int ADDR_W = 18;
    localparam int INS_W  = OPC_W + ADDR_W;

    localparam logic [OPC_W-1:0] OPC_PUSH = 6'h00;
    localparam logic [OPC_W-1:0] OPC_POP  = 6'h01;
    localparam logic [OPC_W-1:0] OPC_ADD  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_MUL  = 6'h03;
    localparam logic [OPC_W-1:0] OPC_HALT = 6'h3F;

    typedef enum logic [2:0] {
        OP_NOP, OP_PUSH, OP_POP, OP_ADD, OP_MUL, OP_HALT
    } op_e;

    typedef enum logic [1:0] {
        SC_HOLD,  // no change
        SC_PUSH,  // new top, others move down
        SC_POP,   // drop top, others move up
        SC_FOLD   // two tops replaced by one value
    } stk_cmd_e;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
(
    input  logic [INS_W-1:0]  ins_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc    = ins_i[INS_W-1:ADDR_W];
        addr_o = ins_i[ADDR_W-1:0];
        case (opc)
            OPC_PUSH: op_o = OP_PUSH;
            OPC_POP:  op_o = OP_POP;
            OPC_ADD:  op_o = OP_ADD;
            OPC_MUL:  op_o = OP_MUL;
            OPC_HALT: op_o = OP_HALT;
            default:  op_o = OP_NOP;
        endcase
    end
endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         mul_i,
    output logic [W-1:0] y_o
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = a_i * b_i;
        y_o  = mul_i ? prod[W-1:0] : a_i + b_i;
    end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile
    import stk_pkg::*;
#(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  stk_cmd_e     cmd_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] top_o,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] ent_d [DEPTH];
    logic [W-1:0] ent_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
        case (cmd_i)
            SC_PUSH: begin
                ent_d[0] = val_i;
                for (int i = 1; i < DEPTH; i++) ent_d[i] = ent_q[i-1];
            end
            SC_POP: begin
                for (int i = 0; i < DEPTH-1; i++) ent_d[i] = ent_q[i+1];
                ent_d[DEPTH-1] = '0;
            end
            SC_FOLD: begin
                ent_d[0] = val_i;
                for (int i = 1; i < DEPTH-1; i++) ent_d[i] = ent_q[i+1];
                ent_d[DEPTH-1] = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end

    assign top_o = ent_q[0];
    assign nxt_o = ent_q[1];

    // R6
    push_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == SC_PUSH |=> ent_q[1] == $past(ent_q[0]));
    // R6
    pop_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == SC_POP |=> ent_q[0] == $past(ent_q[1]));
endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int W     = 64,
    parameter int DEPTH = 8,
    parameter int PC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   ins_addr_o,
    input  logic [INS_W-1:0]  ins_data_i,
    output logic [ADDR_W-1:0] dmem_raddr_o,
    input  logic [W-1:0]      dmem_rdata_i,
    output logic              dmem_wen_o,
    output logic [ADDR_W-1:0] dmem_waddr_o,
    output logic [W-1:0]      dmem_wdata_o,
    output logic              halted_o,
    output logic              err_o
);
    localparam int DW = $clog2(DEPTH + 1);
    localparam logic [DW-1:0] FULL = DW'(DEPTH);
    localparam logic [DW-1:0] ONE  = DW'(1);
    localparam logic [DW-1:0] TWO  = DW'(2);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [DW-1:0]   depth;
        logic            halted;
        logic            err;
    } core_t;

    core_t st_d, st_q;
    op_e              op;
    logic [ADDR_W-1:0] addr;
    stk_cmd_e         cmd;
    logic [W-1:0]     top, nxt, alu_y, push_val;
    logic             wen;

    stk_decode u_dec (.ins_i(ins_data_i), .op_o(op), .addr_o(addr));

    stk_alu #(.W(W)) u_alu (
        .a_i(top), .b_i(nxt), .mul_i(op == OP_MUL), .y_o(alu_y)
    );

    stk_regfile #(.W(W), .DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .val_i(push_val),
        .top_o(top), .nxt_o(nxt)
    );

    always_comb begin
        st_d     = st_q;
        cmd      = SC_HOLD;
        wen      = 1'b0;
        push_val = dmem_rdata_i;
        if (!st_q.halted) begin
            st_d.pc = st_q.pc + 1'b1;
            case (op)
                OP_PUSH: begin
                    if (st_q.depth == FULL) st_d.err = 1'b1;
                    else begin
                        cmd         = SC_PUSH;
                        st_d.depth  = st_q.depth + ONE;
                    end
                end
                OP_POP: begin
                    if (st_q.depth == '0) st_d.err = 1'b1;
                    else begin
                        cmd        = SC_POP;
                        wen        = 1'b1;
                        st_d.depth = st_q.depth - ONE;
                    end
                end
                OP_ADD, OP_MUL: begin
                    if (st_q.depth < TWO) st_d.err = 1'b1;
                    else begin
                        cmd        = SC_FOLD;
                        push_val   = alu_y;
                        st_d.depth = st_q.depth - ONE;
                    end
                end
                OP_HALT: begin
                    st_d.pc     = st_q.pc;
                    st_d.halted = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ins_addr_o   = st_q.pc;
    assign dmem_raddr_o = addr;
    assign dmem_wen_o   = wen;
    assign dmem_waddr_o = addr;
    assign dmem_wdata_o = top;
    assign halted_o     = st_q.halted;
    assign err_o        = st_q.err;

    // R9
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halted |=> st_q.halted && $stable(st_q.pc));
    // R10
    halt_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halted |-> !dmem_wen_o);
    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.depth <= FULL);
    // R8
    empty_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.depth == '0 |-> !dmem_wen_o);
    // R12
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.halted && op != OP_HALT) |=> st_q.pc == PC_W'($past(st_q.pc) + 1'b1));
endmodule

// File: tb/stk_core_bench.sv
module stk_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ins_addr_o;
    logic [23:0] ins_data_i;
    logic [17:0] dmem_raddr_o, dmem_waddr_o;
    logic [63:0] dmem_rdata_i, dmem_wdata_o;
    logic        dmem_wen_o, halted_o, err_o;

    logic [23:0] imem [64];
    logic [63:0] dmem [256];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign ins_data_i   = imem[ins_addr_o[5:0]];
    assign dmem_rdata_i = dmem[dmem_raddr_o[7:0]];
    always @(posedge clk) if (dmem_wen_o) dmem[dmem_waddr_o[7:0]] <= dmem_wdata_o;

    stk_core u_stk_core (
        .clk(clk), .rst_n(rst_n), .ins_addr_o(ins_addr_o), .ins_data_i(ins_data_i),
        .dmem_raddr_o(dmem_raddr_o), .dmem_rdata_i(dmem_rdata_i),
        .dmem_wen_o(dmem_wen_o), .dmem_waddr_o(dmem_waddr_o),
        .dmem_wdata_o(dmem_wdata_o), .halted_o(halted_o), .err_o(err_o)
    );

    function automatic logic [23:0] ins(input logic [5:0] opc, input logic [17:0] a);
        return {opc, a};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) imem[i] = ins(6'h3F, 18'h0);
    endtask

    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_to_halt();
        for (int i = 0; i < 200 && !halted_o; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_prog();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pc", 64'(ins_addr_o), 64'h0);
        chk("R1 halted", 64'(halted_o), 64'h0);
        chk("R1 err", 64'(err_o), 64'h0);
        chk("R1 wen", 64'(dmem_wen_o), 64'h0);
    endtask

    task automatic t_formula();
        clear_prog();
        dmem[8'h00] = 64'd5; dmem[8'h08] = 64'hB0B; dmem[8'h18] = 64'd7;
        imem[0] = ins(6'h00, 18'h1E500);
        imem[1] = ins(6'h00, 18'h1E500);
        imem[2] = ins(6'h00, 18'h1E518);
        imem[3] = ins(6'h03, 18'h1E508);
        imem[4] = ins(6'h02, 18'h1E508);
        imem[5] = ins(6'h01, 18'h1E500);
        restart(); run_to_halt();
        chk("R2 R4 R5 A=A+A*D", dmem[8'h00], 64'd40);
        chk("R3 arith no write", dmem[8'h08], 64'hB0B);
        chk("R8 no error", 64'(err_o), 64'h0);
    endtask

    task automatic t_lifo();
        clear_prog();
        dmem[8'h60] = 64'd1; dmem[8'h61] = 64'd2; dmem[8'h62] = 64'd3;
        imem[0] = ins(6'h00, 18'h60);
        imem[1] = ins(6'h00, 18'h61);
        imem[2] = ins(6'h00, 18'h62);
        imem[3] = ins(6'h01, 18'h70);
        imem[4] = ins(6'h01, 18'h71);
        imem[5] = ins(6'h01, 18'h72);
        restart(); run_to_halt();
        chk("R6 first pop", dmem[8'h70], 64'd3);
        chk("R6 second pop", dmem[8'h71], 64'd2);
        chk("R3 third pop", dmem[8'h72], 64'd1);
    endtask

    task automatic t_wrap();
        clear_prog();
        dmem[8'h80] = 64'hFFFF_FFFF_FFFF_FFFF; dmem[8'h81] = 64'd2;
        dmem[8'h82] = 64'h1_0000_0001; dmem[8'h83] = 64'h1_0000_0003;
        dmem[8'h84] = 64'd10; dmem[8'h85] = 64'd3;
        imem[0] = ins(6'h00, 18'h80);
        imem[1] = ins(6'h00, 18'h81);
        imem[2] = ins(6'h02, 18'h0);
        imem[3] = ins(6'h01, 18'h90);
        imem[4] = ins(6'h00, 18'h82);
        imem[5] = ins(6'h00, 18'h83);
        imem[6] = ins(6'h03, 18'h0);
        imem[7] = ins(6'h01, 18'h91);
        imem[8] = ins(6'h00, 18'h84);
        imem[9] = ins(6'h00, 18'h85);
        imem[10] = ins(6'h03, 18'h0);
        imem[11] = ins(6'h01, 18'h92);
        restart(); run_to_halt();
        chk("R4 sum wraps", dmem[8'h90], 64'd1);
        chk("R5 product truncated", dmem[8'h91], 64'h4_0000_0003);
        chk("R5 plain product", dmem[8'h92], 64'd30);
    endtask

    task automatic t_overflow();
        clear_prog();
        for (int i = 0; i < 9; i++) begin
            dmem[8'hA0 + i] = 64'(i + 1);
            imem[i] = ins(6'h00, 18'hA0 + 18'(i));
        end
        dmem[8'hB0] = '0; dmem[8'hB1] = '0;
        imem[9]  = ins(6'h01, 18'hB0);
        imem[10] = ins(6'h01, 18'hB1);
        restart(); run_to_halt();
        chk("R7 ninth push rejected", dmem[8'hB0], 64'd8);
        chk("R7 order kept", dmem[8'hB1], 64'd7);
        chk("R9 err sticky and run continued", 64'(err_o), 64'h1);
        chk("R9 reached halt", 64'(halted_o), 64'h1);
    endtask

    task automatic t_underflow();
        clear_prog();
        dmem[8'hC0] = 64'hDEAD; dmem[8'hC1] = 64'd11; dmem[8'hC2] = '0;
        imem[0] = ins(6'h01, 18'hC0);
        imem[1] = ins(6'h00, 18'hC1);
        imem[2] = ins(6'h02, 18'h0);
        imem[3] = ins(6'h01, 18'hC2);
        restart();
        @(negedge clk);
        chk("R8 empty pop flags", 64'(err_o), 64'h1);
        run_to_halt();
        chk("R8 empty pop no write", dmem[8'hC0], 64'hDEAD);
        chk("R8 short add leaves entry", dmem[8'hC2], 64'd11);
    endtask

    task automatic t_halt();
        clear_prog();
        dmem[8'hD0] = 64'd9; dmem[8'hD1] = 64'h77;
        imem[0] = ins(6'h00, 18'hD0);
        imem[1] = ins(6'h3F, 18'h0);
        imem[2] = ins(6'h01, 18'hD1);
        restart(); run_to_halt();
        repeat (5) @(negedge clk);
        chk("R10 halted", 64'(halted_o), 64'h1);
        chk("R10 pc frozen", 64'(ins_addr_o), 64'h1);
        chk("R10 no later write", dmem[8'hD1], 64'h77);
    endtask

    task automatic t_nop_and_pc();
        clear_prog();
        dmem[8'hE0] = 64'd42; dmem[8'hE1] = '0;
        imem[0] = ins(6'h00, 18'hE0);
        for (int i = 1; i < 6; i++) imem[i] = ins(6'h05 + 6'(i), 18'hE1);
        imem[6] = ins(6'h01, 18'hE1);
        restart();
        repeat (3) @(negedge clk);
        chk("R12 pc after three clocks", 64'(ins_addr_o), 64'd3);
        run_to_halt();
        chk("R11 unknown ops keep stack", dmem[8'hE1], 64'd42);
        chk("R11 no error", 64'(err_o), 64'h0);
        chk("R12 halt address", 64'(ins_addr_o), 64'd7);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = '0;
        t_reset();
        t_formula();
        t_lifo();
        t_wrap();
        t_overflow();
        t_underflow();
        t_halt();
        t_nop_and_pc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule